// File: doc/BRIEF.md
# Compressed Instruction Class Decoder

This block sorts a 16-bit compressed instruction word into one of twenty-two instruction classes and pulls out the register indices, the opcode bits, the register list and the immediate value that belong to that class. Matching follows a fixed priority, so narrow encodings such as the stack-pointer adjust or the software trap win over the broad encodings that share their leading bits. Words that fit no class are flagged as undefined.

The decode itself is combinational. A single register stage captures the class and the fields whenever the input strobe is high, and raises an output strobe one cycle later. Immediates leave the block already scaled and extended to 32 bits, so an execute stage can use them directly. Fields that a class does not use read as zero.

Top module: `cdec_top`

## Requirements
- R1: Class codes on class_o follow the match order: 0 add/sub register (15:10=000110), 1 add/sub 3-bit immediate (000111), 2 shift by immediate (15:13=000), 3 8-bit immediate ops (001), 4 low ALU (15:10=010000), 5 branch-exchange (15:7=010001110), 6 high-register ops (15:10=010001), 7 PC-relative load (15:11=01001), 8 register-offset load/store (15:12=0101), 9 word offset (0110), 10 byte offset (0111), 11 halfword offset (1000), 12 SP-relative load/store (1001), 13 address generate (1010), 14 SP adjust (15:8=10110000), 15 push/pop (15:12=1011 with 10:9=10), 16 multiple load/store (1100), 17 software trap (15:8=11011111), 18 conditional branch (1101), 19 short branch (15:11=11100), 20 long-branch upper half (11110), 21 long-branch lower half (11111).
- R2: A word with 15:11=00011 decodes as class 0 or 1 (bit 10 selects 1), never as the shift class 2.
- R3: A word with 15:7=010001110 decodes as class 5, while 15:7=010001111 decodes as class 6.
- R4: 15:8=11011111 decodes as class 17, not 18; 15:8=10110000 decodes as class 14, not 15.
- R5: A word that matches no class (1011 words outside classes 14 and 15, and 15:11=11101) gives undef_o=1, class_o=31 and every field zero; every decoded word gives undef_o=0.
- R6: Three-register and shift layouts: class 0 op=bit 9, rd=2:0, rn=5:3, rm=8:6; class 1 op=bit 9, rd=2:0, rn=5:3, imm=8:6; class 2 op=12:11, imm=10:6, rn=5:3, rd=2:0; class 4 op=9:6, rd=rn=2:0, rm=5:3; class 8 op=11:9, rm=8:6, rn=5:3, rd=2:0.
- R7: High-register layouts: class 6 op=9:8, rd=rn={bit 7, 2:0}, rm=6:3; class 5 rm=6:3 with all else zero.
- R8: Branch immediates, sign-extended to 32 bits: class 18 op=11:8 and imm=signed(7:0)*2; class 19 imm=signed(10:0)*2; class 20 imm=signed(10:0)*4096; class 21 imm=unsigned(10:0)*2.
- R9: Memory offsets: classes 9, 10, 11 give op=bit 11, rn=5:3, rd=2:0 and imm=10:6 times 4, 1 and 2; class 7 rd=10:8, rn=15, imm=7:0 times 4; class 12 op=bit 11, rd=10:8, rn=13, imm=7:0 times 4; class 13 op=bit 11, rd=10:8, rn=13 when bit 11 is set else 15, imm=7:0 times 4; class 14 op=bit 7, rd=rn=13, imm=6:0 times 4.
- R10: List and byte forms: class 3 op=12:11, rd=rn=10:8, imm=7:0; class 15 op={bit 11, bit 8}, rn=13, list=7:0; class 16 op=bit 11, rn=10:8, list=7:0; class 17 imm=7:0.
- R11: With valid_i high at a clock edge, valid_o is high after that edge and the outputs show that word's decode; with valid_i low, valid_o is low after the edge.
- R12: With valid_i low at a clock edge, class_o, undef_o and all field outputs keep their values.
- R13: While rst_ni is low, valid_o, undef_o, class_o and all fields are zero.
- R14: Any field a class does not list above reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word strobe |
| instr_i | input | 16 | Instruction word |
| valid_o | output | 1 | Decode result strobe |
| class_o | output | 5 | Class code, 31 when undefined |
| undef_o | output | 1 | Word matches no class |
| rd_o | output | 4 | Destination or data register |
| rn_o | output | 4 | First source or base register |
| rm_o | output | 4 | Second source or offset register |
| op_o | output | 4 | Class-local opcode bits |
| imm_o | output | 32 | Scaled, extended immediate |
| list_o | output | 8 | Register list |

## Verification
Every cycle the assertions check that the output stage holds still while no word is strobed, that a strobe reaches valid_o one cycle later, that an undefined result carries code 31 with blank fields, and that the priority rules hold: no shift result comes from an add/sub word, no high-register result from a branch-exchange word, no conditional branch from a trap word. They also check the split destination of high-register forms and the sign extension of conditional offsets. Only the bench's exhaustive sweep of all 65536 words shows every field layout, every scale factor and every unused field, together with the reset state and the hold behaviour under a changing word.

// File: rtl/cdec_pkg.sv
package cdec_pkg;
  localparam int INSTR_W = 16;
  localparam int DATA_W  = 32;
  localparam int CLS_W   = 5;
  localparam int REG_W   = 4;
  localparam int OP_W    = 4;
  localparam int LIST_W  = 8;
  localparam int NUM_CLS = 22;
  localparam logic [REG_W-1:0] REG_SP = 4'd13;
  localparam logic [REG_W-1:0] REG_PC = 4'd15;

  typedef enum logic [CLS_W-1:0] {
    CLS_ADDSUB_REG = 5'd0,  CLS_ADDSUB_IMM = 5'd1,  CLS_SHIFT    = 5'd2,
    CLS_IMM8       = 5'd3,  CLS_ALU        = 5'd4,  CLS_BX       = 5'd5,
    CLS_ALU_HI     = 5'd6,  CLS_LIT        = 5'd7,  CLS_LS_REG   = 5'd8,
    CLS_LS_WORD    = 5'd9,  CLS_LS_BYTE    = 5'd10, CLS_LS_HALF  = 5'd11,
    CLS_LS_SP      = 5'd12, CLS_ADDR_GEN   = 5'd13, CLS_SP_ADJ   = 5'd14,
    CLS_PUSH_POP   = 5'd15, CLS_LS_MULTI   = 5'd16, CLS_TRAP     = 5'd17,
    CLS_BR_COND    = 5'd18, CLS_BR_SHORT   = 5'd19, CLS_BL_HI    = 5'd20,
    CLS_BL_LO      = 5'd21, CLS_UNDEF      = 5'd31
  } cls_e;

  // index = class code = priority (lower wins)
  localparam logic [INSTR_W-1:0] MATCH_MASK [NUM_CLS] = '{
    16'hFC00, 16'hFC00, 16'hE000, 16'hE000, 16'hFC00, 16'hFF80,
    16'hFC00, 16'hF800, 16'hF000, 16'hF000, 16'hF000, 16'hF000,
    16'hF000, 16'hF000, 16'hFF00, 16'hF600, 16'hF000, 16'hFF00,
    16'hF000, 16'hF800, 16'hF800, 16'hF800};
  localparam logic [INSTR_W-1:0] MATCH_VAL [NUM_CLS] = '{
    16'h1800, 16'h1C00, 16'h0000, 16'h2000, 16'h4000, 16'h4700,
    16'h4400, 16'h4800, 16'h5000, 16'h6000, 16'h7000, 16'h8000,
    16'h9000, 16'hA000, 16'hB000, 16'hB400, 16'hC000, 16'hDF00,
    16'hD000, 16'hE000, 16'hF000, 16'hF800};
endpackage

// File: rtl/cdec_classify.sv
module cdec_classify
  import cdec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output cls_e               cls_o,
  output logic               undef_o
);
  logic [NUM_CLS-1:0] hit;

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_match
    assign hit[g] = (instr_i & MATCH_MASK[g]) == MATCH_VAL[g];
  end

  // scan from lowest priority up so the first match in order is kept
  always_comb begin
    cls_o   = CLS_UNDEF;
    undef_o = 1'b1;
    for (int i = NUM_CLS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        cls_o   = cls_e'(CLS_W'(i));
        undef_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/cdec_fields.sv
module cdec_fields
  import cdec_pkg::*;
(
  input  cls_e              cls_i,
  input  logic [12:0]       instr_i,
  output logic [REG_W-1:0]  rd_o,
  output logic [REG_W-1:0]  rn_o,
  output logic [REG_W-1:0]  rm_o,
  output logic [OP_W-1:0]   op_o,
  output logic [LIST_W-1:0] list_o
);
  logic [REG_W-1:0] r_lo0, r_lo3, r_lo6, r_mid8, r_hi_dst, r_hi_src;

  assign r_lo0    = {1'b0, instr_i[2:0]};
  assign r_lo3    = {1'b0, instr_i[5:3]};
  assign r_lo6    = {1'b0, instr_i[8:6]};
  assign r_mid8   = {1'b0, instr_i[10:8]};
  assign r_hi_dst = {instr_i[7], instr_i[2:0]};
  assign r_hi_src = instr_i[6:3];

  always_comb begin
    rd_o   = '0;
    rn_o   = '0;
    rm_o   = '0;
    op_o   = '0;
    list_o = '0;
    unique case (cls_i)
      CLS_ADDSUB_REG: begin
        op_o = {3'b0, instr_i[9]}; rd_o = r_lo0; rn_o = r_lo3; rm_o = r_lo6;
      end
      CLS_ADDSUB_IMM: begin
        op_o = {3'b0, instr_i[9]}; rd_o = r_lo0; rn_o = r_lo3;
      end
      CLS_SHIFT: begin
        op_o = {2'b0, instr_i[12:11]}; rd_o = r_lo0; rn_o = r_lo3;
      end
      CLS_IMM8: begin
        op_o = {2'b0, instr_i[12:11]}; rd_o = r_mid8; rn_o = r_mid8;
      end
      CLS_ALU: begin
        op_o = instr_i[9:6]; rd_o = r_lo0; rn_o = r_lo0; rm_o = r_lo3;
      end
      CLS_BX: rm_o = r_hi_src;
      CLS_ALU_HI: begin
        op_o = {2'b0, instr_i[9:8]}; rd_o = r_hi_dst; rn_o = r_hi_dst;
        rm_o = r_hi_src;
      end
      CLS_LIT: begin
        rd_o = r_mid8; rn_o = REG_PC;
      end
      CLS_LS_REG: begin
        op_o = {1'b0, instr_i[11:9]}; rd_o = r_lo0; rn_o = r_lo3; rm_o = r_lo6;
      end
      CLS_LS_WORD, CLS_LS_BYTE, CLS_LS_HALF: begin
        op_o = {3'b0, instr_i[11]}; rd_o = r_lo0; rn_o = r_lo3;
      end
      CLS_LS_SP: begin
        op_o = {3'b0, instr_i[11]}; rd_o = r_mid8; rn_o = REG_SP;
      end
      CLS_ADDR_GEN: begin
        op_o = {3'b0, instr_i[11]}; rd_o = r_mid8;
        rn_o = instr_i[11] ? REG_SP : REG_PC;
      end
      CLS_SP_ADJ: begin
        op_o = {3'b0, instr_i[7]}; rd_o = REG_SP; rn_o = REG_SP;
      end
      CLS_PUSH_POP: begin
        op_o = {2'b0, instr_i[11], instr_i[8]}; rn_o = REG_SP;
        list_o = instr_i[7:0];
      end
      CLS_LS_MULTI: begin
        op_o = {3'b0, instr_i[11]}; rn_o = r_mid8; list_o = instr_i[7:0];
      end
      CLS_BR_COND: op_o = instr_i[11:8];
      default: ;
    endcase
  end
endmodule

// File: rtl/cdec_imm.sv
module cdec_imm
  import cdec_pkg::*;
(
  input  cls_e              cls_i,
  input  logic [10:0]       instr_i,
  output logic [DATA_W-1:0] imm_o
);
  localparam int W = DATA_W;

  always_comb begin
    imm_o = '0;
    unique case (cls_i)
      CLS_ADDSUB_IMM: imm_o = W'(instr_i[8:6]);
      CLS_SHIFT, CLS_LS_BYTE: imm_o = W'(instr_i[10:6]);
      CLS_LS_HALF:  imm_o = W'({instr_i[10:6], 1'b0});
      CLS_LS_WORD:  imm_o = W'({instr_i[10:6], 2'b0});
      CLS_IMM8, CLS_TRAP: imm_o = W'(instr_i[7:0]);
      CLS_LIT, CLS_LS_SP, CLS_ADDR_GEN: imm_o = W'({instr_i[7:0], 2'b0});
      CLS_SP_ADJ:   imm_o = W'({instr_i[6:0], 2'b0});
      CLS_BR_COND:  imm_o = {{(W-9){instr_i[7]}}, instr_i[7:0], 1'b0};
      CLS_BR_SHORT: imm_o = {{(W-12){instr_i[10]}}, instr_i[10:0], 1'b0};
      CLS_BL_HI:    imm_o = {{(W-23){instr_i[10]}}, instr_i[10:0], 12'b0};
      CLS_BL_LO:    imm_o = W'({instr_i[10:0], 1'b0});
      default: ;
    endcase
  end
endmodule

// File: rtl/cdec_top.sv
module cdec_top
  import cdec_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [15:0]        instr_i,
  output logic               valid_o,
  output logic [4:0]         class_o,
  output logic               undef_o,
  output logic [3:0]         rd_o,
  output logic [3:0]         rn_o,
  output logic [3:0]         rm_o,
  output logic [3:0]         op_o,
  output logic [31:0]        imm_o,
  output logic [7:0]         list_o
);
  cls_e              cls_d;
  logic              undef_d;
  logic [REG_W-1:0]  rd_d, rn_d, rm_d;
  logic [OP_W-1:0]   op_d;
  logic [LIST_W-1:0] list_d;
  logic [DATA_W-1:0] imm_d;

  cdec_classify u_classify (
    .instr_i (instr_i),
    .cls_o   (cls_d),
    .undef_o (undef_d)
  );

  cdec_fields u_fields (
    .cls_i   (cls_d),
    .instr_i (instr_i[12:0]),
    .rd_o    (rd_d),
    .rn_o    (rn_d),
    .rm_o    (rm_d),
    .op_o    (op_d),
    .list_o  (list_d)
  );

  cdec_imm u_imm (
    .cls_i   (cls_d),
    .instr_i (instr_i[10:0]),
    .imm_o   (imm_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      class_o <= '0;
      undef_o <= 1'b0;
      rd_o    <= '0;
      rn_o    <= '0;
      rm_o    <= '0;
      op_o    <= '0;
      imm_o   <= '0;
      list_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        class_o <= cls_d;
        undef_o <= undef_d;
        rd_o    <= rd_d;
        rn_o    <= rn_d;
        rm_o    <= rm_d;
        op_o    <= op_d;
        imm_o   <= imm_d;
        list_o  <= list_d;
      end
    end
  end

  AST_STROBE_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(class_o) && $stable(undef_o) && $stable(rd_o) &&
    $stable(rn_o) && $stable(rm_o) && $stable(op_o) && $stable(imm_o) &&
    $stable(list_o)); // R12
  AST_UNDEF_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> class_o == 5'd31 && imm_o == '0 && list_o == '0 &&
    rd_o == '0 && op_o == '0); // R5
  AST_SHIFT_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && class_o == CLS_SHIFT |-> $past(instr_i[12:11]) != 2'b11); // R2
  AST_BX_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && class_o == CLS_ALU_HI |-> $past(instr_i[9:7]) != 3'b110); // R3
  AST_TRAP_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && class_o == CLS_BR_COND |-> $past(instr_i[11:8]) != 4'hF); // R4
  AST_HI_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && class_o == CLS_ALU_HI |->
    rd_o == {$past(instr_i[7]), $past(instr_i[2:0])}); // R7
  AST_BR_SEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && class_o == CLS_BR_COND |->
    !imm_o[0] && (imm_o[31:8] == '0 || imm_o[31:8] == '1)); // R8
endmodule

// File: tb/cdec_top_tb_top.sv
module cdec_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic        valid_o, undef_o;
  logic [4:0]  class_o;
  logic [3:0]  rd_o, rn_o, rm_o, op_o;
  logic [31:0] imm_o;
  logic [7:0]  list_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cdec_top dut_i (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid_i), .instr_i (instr_i),
    .valid_o (valid_o), .class_o (class_o), .undef_o (undef_o),
    .rd_o (rd_o), .rn_o (rn_o), .rm_o (rm_o), .op_o (op_o),
    .imm_o (imm_o), .list_o (list_o)
  );

  function automatic logic [31:0] sx(input int v, input int bits, input int mul);
    int s = v;
    if (s >= (1 << (bits - 1))) s = s - (1 << bits);
    return 32'(s * mul);
  endfunction

  task automatic model(input logic [15:0] w, output logic [4:0] c,
                       output logic u, output logic [75:0] f);
    logic [3:0] rd, rn, rm, op;
    logic [31:0] im;
    logic [7:0] ls;
    int v;
    v = int'(w);
    rd = 0; rn = 0; rm = 0; op = 0; im = 0; ls = 0; u = 1'b0; c = 5'd31;
    case (w[15:12])
      4'h0, 4'h1:
        if (w[12:11] == 2'b11) begin
          c = w[10] ? 5'd1 : 5'd0;
          op = 4'((v >> 9) & 1); rd = 4'(v & 7); rn = 4'((v >> 3) & 7);
          if (w[10]) im = 32'((v >> 6) & 7); else rm = 4'((v >> 6) & 7);
        end else begin
          c = 5'd2; op = 4'((v >> 11) & 3); im = 32'((v >> 6) & 31);
          rn = 4'((v >> 3) & 7); rd = 4'(v & 7);
        end
      4'h2, 4'h3: begin
        c = 5'd3; op = 4'((v >> 11) & 3); rd = 4'((v >> 8) & 7); rn = rd;
        im = 32'(v & 255);
      end
      4'h4:
        if (w[11]) begin
          c = 5'd7; rd = 4'((v >> 8) & 7); rn = 4'd15; im = 32'((v & 255) * 4);
        end else if (!w[10]) begin
          c = 5'd4; op = 4'((v >> 6) & 15); rd = 4'(v & 7); rn = rd;
          rm = 4'((v >> 3) & 7);
        end else if (((v >> 7) & 7) == 6) begin
          c = 5'd5; rm = 4'((v >> 3) & 15);
        end else begin
          c = 5'd6; op = 4'((v >> 8) & 3); rd = 4'(((v >> 4) & 8) | (v & 7));
          rn = rd; rm = 4'((v >> 3) & 15);
        end
      4'h5: begin
        c = 5'd8; op = 4'((v >> 9) & 7); rm = 4'((v >> 6) & 7);
        rn = 4'((v >> 3) & 7); rd = 4'(v & 7);
      end
      4'h6, 4'h7, 4'h8: begin
        c = (w[15:12] == 4'h6) ? 5'd9 : (w[15:12] == 4'h7) ? 5'd10 : 5'd11;
        op = 4'((v >> 11) & 1); rn = 4'((v >> 3) & 7); rd = 4'(v & 7);
        im = 32'(((v >> 6) & 31) * ((c == 5'd9) ? 4 : (c == 5'd10) ? 1 : 2));
      end
      4'h9, 4'hA: begin
        c = w[13] ? 5'd13 : 5'd12; op = 4'((v >> 11) & 1);
        rd = 4'((v >> 8) & 7); im = 32'((v & 255) * 4);
        rn = (c == 5'd12 || w[11]) ? 4'd13 : 4'd15;
      end
      4'hB:
        if (((v >> 8) & 15) == 0) begin
          c = 5'd14; op = 4'((v >> 7) & 1); rd = 4'd13; rn = 4'd13;
          im = 32'((v & 127) * 4);
        end else if (((v >> 9) & 3) == 2) begin
          c = 5'd15; op = 4'((((v >> 11) & 1) * 2) + ((v >> 8) & 1));
          rn = 4'd13; ls = 8'(v & 255);
        end
      4'hC: begin
        c = 5'd16; op = 4'((v >> 11) & 1); rn = 4'((v >> 8) & 7);
        ls = 8'(v & 255);
      end
      4'hD:
        if (((v >> 8) & 15) == 15) begin
          c = 5'd17; im = 32'(v & 255);
        end else begin
          c = 5'd18; op = 4'((v >> 8) & 15); im = sx(v & 255, 8, 2);
        end
      4'hE: if (!w[11]) begin c = 5'd19; im = sx(v & 2047, 11, 2); end
      default:
        if (w[11]) begin c = 5'd21; im = 32'((v & 2047) * 2); end
        else begin c = 5'd20; im = sx(v & 2047, 11, 4096); end
    endcase
    if (c == 5'd31) u = 1'b1;
    f = {rd, rn, rm, op, im, ls};
  endtask

  function automatic string cls_tag(input logic [4:0] c);
    case (c)
      5'd0, 5'd1, 5'd2: return "R2";
      5'd5, 5'd6: return "R3";
      5'd14, 5'd15, 5'd17, 5'd18: return "R4";
      5'd31: return "R5";
      default: return "R1";
    endcase
  endfunction

  function automatic string fld_tag(input logic [4:0] c);
    case (c)
      5'd0, 5'd1, 5'd2, 5'd4, 5'd8: return "R6";
      5'd5, 5'd6: return "R7";
      5'd18, 5'd19, 5'd20, 5'd21: return "R8";
      5'd3, 5'd15, 5'd16, 5'd17: return "R10";
      5'd31: return "R14";
      default: return "R9";
    endcase
  endfunction

  task automatic check_word(input logic [15:0] w);
    logic [4:0] ec;
    logic eu;
    logic [75:0] ef, af;
    model(w, ec, eu, ef);
    af = {rd_o, rn_o, rm_o, op_o, imm_o, list_o};
    n_chk++;
    if ({class_o, undef_o} !== {ec, eu}) begin
      n_fail++;
      $display("FAIL %s word %h: class/undef %0d/%0b expected %0d/%0b",
               cls_tag(ec), w, class_o, undef_o, ec, eu);
    end
    n_chk++;
    if (af !== ef) begin
      n_fail++;
      $display("FAIL %s word %h: fields %h expected %h", fld_tag(ec), w, af, ef);
    end
  endtask

  task automatic expect_bit(input string tag, input logic act, input logic exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    // R13: reset state
    n_chk++;
    if ({valid_o, undef_o, class_o, rd_o, rn_o, rm_o, op_o, imm_o, list_o} !== '0) begin
      n_fail++;
      $display("FAIL R13: outputs %b expected all zero",
               {valid_o, undef_o, class_o, rd_o, rn_o, rm_o, op_o, imm_o, list_o});
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R11 and full sweep of every word, one per cycle
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      instr_i = 16'(i);
      valid_i = 1'b1;
      @(posedge clk);
      #1;
      if (i == 0) expect_bit("R11 valid_o after strobe", valid_o, 1'b1);
      check_word(16'(i));
    end

    // R12: hold while strobe low, with the word changing
    @(negedge clk);
    instr_i = 16'h4701;
    valid_i = 1'b1;
    @(posedge clk);
    #1;
    check_word(16'h4701);
    @(negedge clk);
    instr_i = 16'hDF12;
    valid_i = 1'b0;
    @(posedge clk);
    #1;
    expect_bit("R11 valid_o drops", valid_o, 1'b0);
    check_word(16'h4701);  // R12
    @(negedge clk);
    instr_i = 16'hB100;
    @(posedge clk);
    #1;
    check_word(16'h4701);  // R12

    // R5 undefined after a hold, then R4 narrow class
    @(negedge clk);
    instr_i = 16'hE9AB;
    valid_i = 1'b1;
    @(posedge clk);
    #1;
    check_word(16'hE9AB);
    @(negedge clk);
    instr_i = 16'hB07F;
    @(posedge clk);
    #1;
    check_word(16'hB07F);
    @(negedge clk);
    valid_i = 1'b0;
    @(posedge clk);
    #1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule